// File: doc/BRIEF.md
# Oscillator Enable, Ready and Lock Controller

This block decides when a single oscillator runs and when its output may be trusted. A software control word picks one of three run policies: held off, held on, or run-on-request. Under run-on-request the oscillator runs while any clock branch drives its request line. Two override bits are also provided. One makes the oscillator ignore hardware requests. The other keeps it running whatever the requests are. The oscillator itself is not modelled. A tick input, one pulse per oscillator period, stands in for it.

After the oscillator is enabled, the ready flag stays low until a programmed number of oscillator ticks has been counted. In crystal mode, that count is never allowed to fall below a crystal-safe floor. The timing word may only be changed while the oscillator is fully stopped. The trim word may only be changed while an external calibration-busy flag is low. A write that breaks either rule is dropped and answered with an error pulse. A 16-bit key register freezes both words. The matching key opens them again and any other value closes them. Writes made while the words are frozen are silently discarded.

Top module: `osc_enable_ctrl`

## Requirements
- R1: After reset the key lock is open, the run policy is on-request (control word reads 0x0002), the timing word reads 0x0100 (crystal mode, 256 ticks), the trim word reads 0x0000, and the status word (bit0 enabled, bit1 ready, bit2 locked) reads 0.
- R2: The control word holds policy in bits [1:0] (0 held off, 1 held on, 2 on-request, 3 treated as held off), the ignore-requests bit in bit 2 and the force-run bit in bit 3. With force-run clear and policy held off, `osc_en` is low whatever the requests.
- R3: Under the on-request policy, with ignore-requests clear, `osc_en` equals the OR of `req` as sampled one clock earlier.
- R4: With ignore-requests set and force-run clear, the requests have no effect on `osc_en`.
- R5: Force-run set drives `osc_en` high one clock after the control write, under any policy and any requests.
- R6: `osc_rdy` rises once `osc_tick` has been high on as many clock edges as the effective timeout while `osc_en` was high. Ticks seen while disabled do not count.
- R7: `osc_rdy` falls in the same cycle that `osc_en` falls. A new enable restarts the tick count from zero.
- R8: The timing word holds the timeout in bits [14:0] and an external-source flag in bit 15. With the flag clear, the effective timeout is the larger of the field and 256. With the flag set, the field is used as written, and 0 makes `osc_rdy` follow `osc_en` at once.
- R9: A write to the timing word (address 1) while `osc_en` is high and the lock is open is dropped, and `err` is high in that write cycle.
- R10: A write to the trim word (address 2, bits [7:0]) while `cal_busy` is high and the lock is open is dropped, and `err` is high in that write cycle.
- R11: Writing 0x1A20 to the key register (address 3) opens the lock. Any other value closes it. Bit 0 of address 3, and bit 2 of the status word (address 4), read the lock state.
- R12: While locked, writes to the timing and trim words leave them unchanged and raise no error, and reads return the stored values.
- R13: `err` is high only in a cycle with `wr_en` high. Reads never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; rdata is zero when low |
| addr | input | 3 | Register address (0 control, 1 timing, 2 trim, 3 key, 4 status) |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational from addr |
| err | output | 1 | Write error response, same cycle as the write |
| req | input | NUM_REQ | On-request lines from clock branches |
| cal_busy | input | 1 | Calibration in progress; blocks trim writes |
| osc_tick | input | 1 | One pulse per oscillator period |
| osc_en | output | 1 | Oscillator enable |
| osc_rdy | output | 1 | Oscillator output stable |

## Verification
A wrong enable decision shows on `osc_en` one clock after the control word or the requests change, so the bench checks the enable after every randomised policy and request pattern. A wrong count or floor shows as `osc_rdy` rising one tick early or late, so ready is sampled at the exact tick on both sides of the threshold. A corrupt lock or blocking decision shows at once on `err`, or on the next readback of the guarded word, and each such write is followed by a read.

// File: rtl/osc_ctl_pkg.sv
package osc_ctl_pkg;

  localparam int DATA_W = 16;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_CFG  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CAL  = 3'd2;
  localparam logic [ADDR_W-1:0] A_KEY  = 3'd3;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd4;

  typedef enum logic [1:0] {
    POL_OFF    = 2'd0,
    POL_ON     = 2'd1,
    POL_DEMAND = 2'd2,
    POL_RSVD   = 2'd3
  } run_pol_e;

  typedef struct packed {
    logic     force_run;
    logic     ign_req;
    run_pol_e pol;
  } ctrl_t;

  // Effective startup count: crystal mode never goes below the floor.
  function automatic logic [DATA_W-1:0] eff_timeout(
      input logic [DATA_W-1:0] field,
      input logic              ext_src,
      input logic [DATA_W-1:0] floor_v);
    if (ext_src || field >= floor_v) return field;
    return floor_v;
  endfunction

  // Run decision for one control word and the reduced request.
  function automatic logic run_wanted(input ctrl_t c, input logic any_req);
    logic r;
    r = c.force_run;
    if (c.pol == POL_ON) r = 1'b1;
    if (c.pol == POL_DEMAND && !c.ign_req && any_req) r = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/osc_req_arbiter.sv
module osc_req_arbiter
  import osc_ctl_pkg::*;
#(
  parameter int NUM_REQ = 4
) (
  input  ctrl_t              ctrl,
  input  logic [NUM_REQ-1:0] req,
  output logic               any_req,
  output logic               want
);
  logic [NUM_REQ:0] chain;

  assign chain[0] = 1'b0;
  for (genvar i = 0; i < NUM_REQ; i++) begin : g_or
    assign chain[i+1] = chain[i] | req[i];
  end

  assign any_req = chain[NUM_REQ];
  assign want    = run_wanted(ctrl, any_req);
endmodule

// File: rtl/osc_startup_timer.sv
module osc_startup_timer #(
  parameter int TMO_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             want,
  input  logic             tick,
  input  logic [TMO_W-1:0] limit,
  output logic             osc_en,
  output logic             osc_rdy,
  output logic [TMO_W-1:0] cnt,
  output logic             cnt_step
);
  logic             en_q;
  logic [TMO_W-1:0] cnt_q;

  assign cnt_step = en_q && tick && (cnt_q < limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      en_q <= want;
      if (!en_q)         cnt_q <= '0;
      else if (cnt_step) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign osc_en  = en_q;
  assign osc_rdy = en_q && (cnt_q >= limit);
  assign cnt     = cnt_q;
endmodule

// File: rtl/osc_cfg_regs.sv
module osc_cfg_regs
  import osc_ctl_pkg::*;
#(
  parameter int          TMO_W      = 15,
  parameter int          CAL_W      = 8,
  parameter int          RESET_TMO  = 256,
  parameter logic [15:0] UNLOCK_KEY = 16'h1A20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              cal_busy,
  input  logic              osc_en,
  input  logic              osc_rdy,
  output logic [DATA_W-1:0] rdata,
  output logic              err,
  output ctrl_t             ctrl,
  output logic [TMO_W-1:0]  tmo_field,
  output logic              ext_src,
  output logic [CAL_W-1:0]  cal,
  output logic              locked,
  output logic              cfg_block,
  output logic              cal_block
);
  ctrl_t            ctrl_q;
  logic [TMO_W-1:0] tmo_q;
  logic             ext_q;
  logic [CAL_W-1:0] cal_q;
  logic             lock_q;

  logic wr_ctrl, wr_cfg, wr_cal, wr_key;
  logic cfg_take, cal_take;

  assign wr_ctrl = wr_en && addr == A_CTRL;
  assign wr_cfg  = wr_en && addr == A_CFG;
  assign wr_cal  = wr_en && addr == A_CAL;
  assign wr_key  = wr_en && addr == A_KEY;

  // Lock wins: a frozen word swallows writes quietly.
  assign cfg_block = wr_cfg && !lock_q && osc_en;
  assign cal_block = wr_cal && !lock_q && cal_busy;
  assign cfg_take  = wr_cfg && !lock_q && !osc_en;
  assign cal_take  = wr_cal && !lock_q && !cal_busy;
  assign err       = cfg_block || cal_block;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '{force_run: 1'b0, ign_req: 1'b0, pol: POL_DEMAND};
      tmo_q  <= TMO_W'(RESET_TMO);
      ext_q  <= 1'b0;
      cal_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(wdata[$bits(ctrl_t)-1:0]);
      if (cfg_take) begin
        tmo_q <= wdata[TMO_W-1:0];
        ext_q <= wdata[DATA_W-1];
      end
      if (cal_take) cal_q <= wdata[CAL_W-1:0];
      if (wr_key)   lock_q <= (wdata != UNLOCK_KEY);
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        A_CTRL: rdata[$bits(ctrl_t)-1:0] = ctrl_q;
        A_CFG: begin
          rdata[TMO_W-1:0]  = tmo_q;
          rdata[DATA_W-1]   = ext_q;
        end
        A_CAL:  rdata[CAL_W-1:0] = cal_q;
        A_KEY:  rdata[0] = lock_q;
        A_STAT: rdata[2:0] = {lock_q, osc_rdy, osc_en};
        default: rdata = '0;
      endcase
    end
  end

  assign ctrl      = ctrl_q;
  assign tmo_field = tmo_q;
  assign ext_src   = ext_q;
  assign cal       = cal_q;
  assign locked    = lock_q;
endmodule

// File: rtl/osc_enable_ctrl.sv
module osc_enable_ctrl
  import osc_ctl_pkg::*;
#(
  parameter int          NUM_REQ    = 4,
  parameter int          TMO_W      = 15,
  parameter int          CAL_W      = 8,
  parameter int          MIN_XTAL   = 256,
  parameter int          RESET_TMO  = 256,
  parameter logic [15:0] UNLOCK_KEY = 16'h1A20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [2:0]         addr,
  input  logic [15:0]        wdata,
  output logic [15:0]        rdata,
  output logic               err,
  input  logic [NUM_REQ-1:0] req,
  input  logic               cal_busy,
  input  logic               osc_tick,
  output logic               osc_en,
  output logic               osc_rdy
);
  ctrl_t             ctrl;
  logic [TMO_W-1:0]  tmo_field;
  logic              ext_src;
  logic [CAL_W-1:0]  cal;
  logic              locked;
  logic              cfg_block;
  logic              cal_block;
  logic              any_req;
  logic              want;
  logic [TMO_W-1:0]  limit;
  logic [TMO_W-1:0]  cnt;
  logic              cnt_step;
  logic [DATA_W-1:0] cfg_word;
  logic [DATA_W-1:0] limit_wide;

  assign cfg_word   = {ext_src, {(DATA_W-1-TMO_W){1'b0}}, tmo_field};
  assign limit_wide = eff_timeout(DATA_W'(tmo_field), ext_src, DATA_W'(MIN_XTAL));
  assign limit      = limit_wide[TMO_W-1:0];

  osc_cfg_regs #(
    .TMO_W(TMO_W), .CAL_W(CAL_W), .RESET_TMO(RESET_TMO), .UNLOCK_KEY(UNLOCK_KEY)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .cal_busy(cal_busy), .osc_en(osc_en), .osc_rdy(osc_rdy),
    .rdata(rdata), .err(err), .ctrl(ctrl), .tmo_field(tmo_field),
    .ext_src(ext_src), .cal(cal), .locked(locked),
    .cfg_block(cfg_block), .cal_block(cal_block)
  );

  osc_req_arbiter #(.NUM_REQ(NUM_REQ)) u_arb (
    .ctrl(ctrl), .req(req), .any_req(any_req), .want(want)
  );

  osc_startup_timer #(.TMO_W(TMO_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .want(want), .tick(osc_tick), .limit(limit),
    .osc_en(osc_en), .osc_rdy(osc_rdy), .cnt(cnt), .cnt_step(cnt_step)
  );
endmodule

// File: rtl/osc_enable_ctrl_chk.sv
module osc_enable_ctrl_chk
  import osc_ctl_pkg::*;
#(
  parameter int TMO_W    = 15,
  parameter int CAL_W    = 8,
  parameter int MIN_XTAL = 256
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [2:0]        addr,
  input logic              err,
  input logic              cal_busy,
  input logic              osc_en,
  input logic              osc_rdy,
  input logic              locked,
  input logic              ext_src,
  input logic [TMO_W-1:0]  cnt,
  input logic [15:0]       cfg_word,
  input logic [CAL_W-1:0]  cal,
  input logic              cfg_block,
  input logic              cal_block
);
  assert_rdy_needs_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> !osc_rdy);

  assert_restart_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(osc_en) |-> cnt == '0);

  assert_xtal_floor_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_rdy && !ext_src) |-> (int'(cnt) >= MIN_XTAL));

  assert_cfg_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CFG && osc_en && !locked) |-> err);

  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_block |=> $stable(cfg_word));

  assert_cal_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CAL && cal_busy && !locked) |-> err);

  assert_cal_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cal_block |=> $stable(cal));

  assert_locked_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && locked && (addr == A_CFG || addr == A_CAL)) |-> !err);

  assert_locked_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && locked && (addr == A_CFG || addr == A_CAL)) |=> ($stable(cfg_word) && $stable(cal)));

  assert_err_on_write_R13: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> wr_en);
endmodule

bind osc_enable_ctrl osc_enable_ctrl_chk #(
  .TMO_W(TMO_W), .CAL_W(CAL_W), .MIN_XTAL(MIN_XTAL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .err(err),
  .cal_busy(cal_busy), .osc_en(osc_en), .osc_rdy(osc_rdy), .locked(locked),
  .ext_src(ext_src), .cnt(cnt), .cfg_word(cfg_word), .cal(cal),
  .cfg_block(cfg_block), .cal_block(cal_block)
);

// File: tb/sim_osc_enable_ctrl.sv
module sim_osc_enable_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NREQ = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wr_en = 1'b0;
  logic            rd_en = 1'b0;
  logic [2:0]      addr = '0;
  logic [15:0]     wdata = '0;
  logic [15:0]     rdata;
  logic            err;
  logic [NREQ-1:0] req = '0;
  logic            cal_busy = 1'b0;
  logic            osc_tick = 1'b0;
  logic            osc_en;
  logic            osc_rdy;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  osc_enable_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .err(err), .req(req), .cal_busy(cal_busy),
    .osc_tick(osc_tick), .osc_en(osc_en), .osc_rdy(osc_rdy)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d, output logic e);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    #1 e = err;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    chk("R13 read raises no err", {15'b0, err}, 16'h0);
    rd_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      osc_tick = 1'b1;
    end
    @(negedge clk);
    osc_tick = 1'b0;
  endtask

  // Bench-side restatement of the run rule.
  function automatic logic model_en(input logic [3:0] c, input logic [NREQ-1:0] r);
    if (c[3]) return 1'b1;
    case (c[1:0])
      2'd1: return 1'b1;
      2'd2: return !c[2] && (r != '0);
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: got hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic        e;
    logic [15:0] d;
    void'($urandom(32'd1234));
    step(3);
    rst_n = 1'b1;

    // R1 reset state
    rd(3'd4, d); chk("R1 status", d, 16'h0000);
    rd(3'd0, d); chk("R1 control", d, 16'h0002);
    rd(3'd1, d); chk("R1 timing", d, 16'h0100);
    rd(3'd2, d); chk("R1 trim", d, 16'h0000);
    rd(3'd3, d); chk("R1 lock open", d, 16'h0000);

    // R3 on-request follows requests one clock later
    @(negedge clk); req = 4'b0100;
    #1 chk("R3 no change same cycle", {15'b0, osc_en}, 16'h0);
    step(1); chk("R3 enabled by request", {15'b0, osc_en}, 16'h1);
    req = '0;
    step(1); chk("R3 released", {15'b0, osc_en}, 16'h0);

    // R4 ignore requests
    wr(3'd0, 16'h0006, e);
    req = '1;
    step(2); chk("R4 requests ignored", {15'b0, osc_en}, 16'h0);

    // R2 held off with requests
    wr(3'd0, 16'h0000, e);
    step(2); chk("R2 held off", {15'b0, osc_en}, 16'h0);

    // R5 force-run under held off, no requests
    req = '0;
    wr(3'd0, 16'h0008, e);
    step(1); chk("R5 forced on", {15'b0, osc_en}, 16'h1);

    // R9 timing write while running
    wr(3'd1, 16'h8005, e); chk("R9 err on running write", {15'b0, e}, 16'h1);
    rd(3'd1, d); chk("R9 timing kept", d, 16'h0100);
    wr(3'd0, 16'h0000, e);
    step(2);
    wr(3'd1, 16'h8005, e); chk("R9 no err while stopped", {15'b0, e}, 16'h0);
    rd(3'd1, d); chk("R9 timing written", d, 16'h8005);

    // R6 ticks while disabled are not counted; threshold 5
    ticks(10);
    wr(3'd0, 16'h0001, e);
    step(1); chk("R6 enabled", {15'b0, osc_en}, 16'h1);
    chk("R6 not ready at start", {15'b0, osc_rdy}, 16'h0);
    ticks(4); chk("R6 not ready after 4", {15'b0, osc_rdy}, 16'h0);
    ticks(1); chk("R6 ready after 5", {15'b0, osc_rdy}, 16'h1);

    // R7 ready falls with enable, count restarts
    wr(3'd0, 16'h0000, e);
    step(1); chk("R7 enable dropped", {15'b0, osc_en}, 16'h0);
    chk("R7 ready dropped together", {15'b0, osc_rdy}, 16'h0);
    wr(3'd0, 16'h0001, e);
    step(1);
    ticks(4); chk("R7 restart not ready at 4", {15'b0, osc_rdy}, 16'h0);
    ticks(1); chk("R7 restart ready at 5", {15'b0, osc_rdy}, 16'h1);

    // R8 crystal floor
    wr(3'd0, 16'h0000, e); step(2);
    wr(3'd1, 16'h0005, e);
    wr(3'd0, 16'h0001, e); step(1);
    ticks(255); chk("R8 floor not ready at 255", {15'b0, osc_rdy}, 16'h0);
    ticks(1);   chk("R8 floor ready at 256", {15'b0, osc_rdy}, 16'h1);
    // R8 external source, zero timeout
    wr(3'd0, 16'h0000, e); step(2);
    wr(3'd1, 16'h8000, e);
    wr(3'd0, 16'h0001, e); step(1);
    chk("R8 ext zero en", {15'b0, osc_en}, 16'h1);
    chk("R8 ext zero ready at once", {15'b0, osc_rdy}, 16'h1);
    wr(3'd0, 16'h0000, e); step(2);

    // R10 trim write under calibration
    cal_busy = 1'b1;
    wr(3'd2, 16'h005A, e); chk("R10 err while busy", {15'b0, e}, 16'h1);
    rd(3'd2, d); chk("R10 trim kept", d, 16'h0000);
    cal_busy = 1'b0;
    wr(3'd2, 16'h005A, e); chk("R10 no err when idle", {15'b0, e}, 16'h0);
    rd(3'd2, d); chk("R10 trim written", d, 16'h005A);

    // R11 lock with wrong key
    wr(3'd3, 16'h1234, e);
    rd(3'd3, d); chk("R11 locked", d, 16'h0001);
    rd(3'd4, d); chk("R11 status lock bit", d, 16'h0004);
    // R12 frozen words
    wr(3'd1, 16'h0300, e); chk("R12 timing no err", {15'b0, e}, 16'h0);
    rd(3'd1, d); chk("R12 timing frozen", d, 16'h8000);
    cal_busy = 1'b1;
    wr(3'd2, 16'h0011, e); chk("R12 trim no err under busy", {15'b0, e}, 16'h0);
    cal_busy = 1'b0;
    wr(3'd2, 16'h0011, e);
    rd(3'd2, d); chk("R12 trim frozen", d, 16'h005A);
    wr(3'd0, 16'h0001, e); step(1);
    wr(3'd1, 16'h0300, e); chk("R12 lock beats running block", {15'b0, e}, 16'h0);
    wr(3'd0, 16'h0000, e); step(2);
    // R11 unlock
    wr(3'd3, 16'h1A20, e);
    rd(3'd3, d); chk("R11 unlocked", d, 16'h0000);
    wr(3'd1, 16'h0300, e);
    rd(3'd1, d); chk("R11 timing writable again", d, 16'h0300);

    // R13 idle cycles raise no err
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); addr = 3'(i); #1;
      chk("R13 idle no err", {15'b0, err}, 16'h0);
    end

    // Random run-policy and request patterns (R2..R5)
    for (int i = 0; i < 60; i++) begin
      logic [3:0]      c;
      logic [NREQ-1:0] r;
      c = 4'($urandom);
      r = NREQ'($urandom);
      @(negedge clk); req = r;
      wr(3'd0, {12'b0, c}, e);
      step(1);
      chk("R3 R4 R5 random run decision", {15'b0, osc_en}, {15'b0, model_en(c, r)});
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule